// File: doc/BRIEF.md
# Vectored Interrupt Controller with Register Bus

This block gathers up to 32 interrupt request lines into one processor interrupt. Each line is latched into a status register. A per-line enable masks the latched requests. A two-bit master switch gates the combined output. Software uses a small word-addressed register bus to look at status, pending and enable state. It reads a vector register to learn which line to service, and it clears latched requests by writing ones to an acknowledge register.

The sense of each line is fixed when the block is built, through a bit mask parameter. An edge line latches once on each rising edge of its synchronised input. A level line latches on every cycle its synchronised input is high. A level request therefore cannot be acknowledged away while its source still drives it. Enable bits can be replaced with one write. They can also be changed without a read-modify-write, through separate set-only and clear-only registers.

Registers sit at byte offsets in steps of four: status 0x00, pending 0x04, enable 0x08, acknowledge 0x0C, enable-set 0x10, enable-clear 0x14, vector 0x18, master 0x1C. Bit n of every line-wide register belongs to line n. An access whose two low address bits are not zero has no effect and reads zero. Read data is registered, so it appears on the bus one clock after the read strobe.

Top module: `vec_irq_ctrl`

## Requirements
- R1: Synchronous reset clears status, enable and master to zero and drives `irq_o` low. After reset the vector register reads 0xFFFFFFFF.
- R2: A line whose EDGE_MASK bit is 1 sets its status bit once per rising edge of its input. The bit stays set after the input falls. If the input is held high, the bit stays clear after an acknowledge.
- R3: A line whose EDGE_MASK bit is 0 sets its status bit on every cycle its synchronised input is high. An acknowledge of that bit has no effect while the input stays high.
- R4: A write to offset 0x0C clears each status bit whose written bit is 1. Writing 0xFFFFFFFF clears all of them.
- R5: A write to offset 0x08 replaces the enable register, and a read of 0x08 returns it. Writing zero disables every line.
- R6: A write to offset 0x10 sets each enable bit whose written bit is 1 and leaves every other enable bit as it was.
- R7: A write to offset 0x14 clears each enable bit whose written bit is 1 and leaves every other enable bit as it was.
- R8: A read of offset 0x04 returns status AND enable.
- R9: `irq_o` is high, one cycle after the state that causes it, exactly when pending is non-zero and both master bits (bit 0 and bit 1 of offset 0x1C) are 1.
- R10: A read of offset 0x18 returns the index of the lowest-numbered pending line, or 0xFFFFFFFF when nothing is pending.
- R11: Writes to status (0x00), pending (0x04) and vector (0x18) are ignored. Acknowledge, enable-set and enable-clear read as zero.
- R12: The master register keeps only bits 1:0 of a write, and its other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Byte address of the register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data, valid one cycle after `bus_rd` |
| irq_lines | input | NUM_LINES | Interrupt request inputs, asynchronous |
| irq_o | output | 1 | Registered interrupt to the processor |

## Verification
The bench builds the block with 32 lines, two synchroniser stages and EDGE_MASK = 0x000000FF. That setting puts edge lines (1, 2 and 4) and a level line (8) side by side in one instance. With it, the bench can compare latch-and-hold behaviour against reassert-while-high behaviour directly. It can also check lowest-index arbitration between lines of different sense. The enable set, clear and direct-write paths are exercised against each other on the same line bits.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int VIC_ADDR_W = 5;

  typedef enum logic [2:0] {
    SEL_STATUS = 3'd0,
    SEL_PEND   = 3'd1,
    SEL_ENABLE = 3'd2,
    SEL_ACK    = 3'd3,
    SEL_SETEN  = 3'd4,
    SEL_CLREN  = 3'd5,
    SEL_VECTOR = 3'd6,
    SEL_MASTER = 3'd7
  } vic_sel_e;
endpackage

// File: rtl/vic_sense.sv
module vic_sense #(
  parameter int                   NUM_LINES   = 32,
  parameter int                   SYNC_STAGES = 2,
  parameter logic [NUM_LINES-1:0] EDGE_MASK   = '1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] lines_i,
  output logic [NUM_LINES-1:0] set_o
);
  localparam int TOP = SYNC_STAGES - 1;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic [SYNC_STAGES-1:0] sh;

    always_ff @(posedge clk) begin
      if (rst) begin
        sh <= '0;
      end else begin
        sh[0] <= lines_i[i];
        for (int k = 1; k < SYNC_STAGES; k++) sh[k] <= sh[k-1];
      end
    end

    if (EDGE_MASK[i]) begin : g_edge
      logic prev;
      always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= sh[TOP];
      end
      assign set_o[i] = sh[TOP] & ~prev;
    end else begin : g_level
      assign set_o[i] = sh[TOP];
    end
  end
endmodule

// File: rtl/vic_prio.sv
module vic_prio #(
  parameter int NUM_LINES = 32,
  parameter int IDX_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic [NUM_LINES-1:0] req_i,
  output logic                 valid_o,
  output logic [IDX_W-1:0]     idx_o
);
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        valid_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/vic_regs.sv
module vic_regs
  import vic_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int DATA_W    = 32,
  parameter int IDX_W     = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [VIC_ADDR_W-1:0] addr_i,
  input  logic                  wr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  input  logic                  rd_i,
  output logic [DATA_W-1:0]     rdata_o,
  input  logic [NUM_LINES-1:0]  set_i,
  input  logic                  vec_valid_i,
  input  logic [IDX_W-1:0]      vec_idx_i,
  output logic [NUM_LINES-1:0]  status_o,
  output logic [NUM_LINES-1:0]  enable_o,
  output logic [NUM_LINES-1:0]  pend_o,
  output logic [1:0]            master_o,
  output logic                  irq_o
);
  logic [NUM_LINES-1:0] status_q, enable_q;
  logic [NUM_LINES-1:0] wbits;
  logic [1:0]           master_q;
  logic                 irq_q;
  logic [DATA_W-1:0]    rdata_q, rdata_d;
  logic                 aligned;
  vic_sel_e             sel;
  logic                 w_ack, w_en, w_set, w_clr, w_mst;

  assign aligned = (addr_i[1:0] == 2'b00);
  assign sel     = vic_sel_e'(addr_i[4:2]);
  assign wbits   = wdata_i[NUM_LINES-1:0];

  assign w_ack = wr_i && aligned && (sel == SEL_ACK);
  assign w_en  = wr_i && aligned && (sel == SEL_ENABLE);
  assign w_set = wr_i && aligned && (sel == SEL_SETEN);
  assign w_clr = wr_i && aligned && (sel == SEL_CLREN);
  assign w_mst = wr_i && aligned && (sel == SEL_MASTER);

  function automatic logic [DATA_W-1:0] widen(input logic [NUM_LINES-1:0] v);
    logic [DATA_W-1:0] r;
    r = '0;
    r[NUM_LINES-1:0] = v;
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] widen_idx(input logic [IDX_W-1:0] v);
    logic [DATA_W-1:0] r;
    r = '0;
    r[IDX_W-1:0] = v;
    return r;
  endfunction

  // New requests win over an acknowledge in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
    end else begin
      status_q <= (status_q & ~(w_ack ? wbits : '0)) | set_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      enable_q <= '0;
    end else if (w_en) begin
      enable_q <= wbits;
    end else if (w_set) begin
      enable_q <= enable_q | wbits;
    end else if (w_clr) begin
      enable_q <= enable_q & ~wbits;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        master_q <= 2'b00;
    else if (w_mst) master_q <= wdata_i[1:0];
  end

  assign pend_o = status_q & enable_q;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= (|pend_o) && (master_q == 2'b11);
  end

  always_comb begin
    rdata_d = '0;
    if (aligned) begin
      unique case (sel)
        SEL_STATUS: rdata_d = widen(status_q);
        SEL_PEND:   rdata_d = widen(pend_o);
        SEL_ENABLE: rdata_d = widen(enable_q);
        SEL_VECTOR: rdata_d = vec_valid_i ? widen_idx(vec_idx_i) : '1;
        SEL_MASTER: rdata_d[1:0] = master_q;
        default:    rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       rdata_q <= '0;
    else if (rd_i) rdata_q <= rdata_d;
  end

  assign rdata_o  = rdata_q;
  assign status_o = status_q;
  assign enable_o = enable_q;
  assign master_o = master_q;
  assign irq_o    = irq_q;
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vic_pkg::*;
#(
  parameter int                   NUM_LINES   = 32,
  parameter int                   DATA_W      = 32,
  parameter int                   SYNC_STAGES = 2,
  parameter logic [NUM_LINES-1:0] EDGE_MASK   = '1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [VIC_ADDR_W-1:0] bus_addr,
  input  logic                  bus_wr,
  input  logic [DATA_W-1:0]     bus_wdata,
  input  logic                  bus_rd,
  output logic [DATA_W-1:0]     bus_rdata,
  input  logic [NUM_LINES-1:0]  irq_lines,
  output logic                  irq_o
);
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

  logic [NUM_LINES-1:0] set_w, status_w, enable_w, pend_w;
  logic [1:0]           master_w;
  logic                 vec_valid_w;
  logic [IDX_W-1:0]     vec_idx_w;

  vic_sense #(
    .NUM_LINES  (NUM_LINES),
    .SYNC_STAGES(SYNC_STAGES),
    .EDGE_MASK  (EDGE_MASK)
  ) u_sense (
    .clk    (clk),
    .rst    (rst),
    .lines_i(irq_lines),
    .set_o  (set_w)
  );

  vic_prio #(
    .NUM_LINES(NUM_LINES),
    .IDX_W    (IDX_W)
  ) u_prio (
    .req_i  (pend_w),
    .valid_o(vec_valid_w),
    .idx_o  (vec_idx_w)
  );

  vic_regs #(
    .NUM_LINES(NUM_LINES),
    .DATA_W   (DATA_W),
    .IDX_W    (IDX_W)
  ) u_regs (
    .clk        (clk),
    .rst        (rst),
    .addr_i     (bus_addr),
    .wr_i       (bus_wr),
    .wdata_i    (bus_wdata),
    .rd_i       (bus_rd),
    .rdata_o    (bus_rdata),
    .set_i      (set_w),
    .vec_valid_i(vec_valid_w),
    .vec_idx_i  (vec_idx_w),
    .status_o   (status_w),
    .enable_o   (enable_w),
    .pend_o     (pend_w),
    .master_o   (master_w),
    .irq_o      (irq_o)
  );
endmodule

// File: rtl/vic_checker.sv
module vic_checker #(
  parameter int NUM_LINES = 32,
  parameter int DATA_W    = 32,
  parameter int IDX_W     = 5
) (
  input logic                 clk,
  input logic                 rst,
  input logic [4:0]           bus_addr,
  input logic                 bus_wr,
  input logic [DATA_W-1:0]    bus_wdata,
  input logic                 irq_o,
  input logic [NUM_LINES-1:0] set_w,
  input logic [NUM_LINES-1:0] status_w,
  input logic [NUM_LINES-1:0] enable_w,
  input logic [NUM_LINES-1:0] pend_w,
  input logic [1:0]           master_w,
  input logic                 vec_valid_w,
  input logic [IDX_W-1:0]     vec_idx_w
);
  logic wr_ack, wr_set, wr_clr;
  assign wr_ack = bus_wr && (bus_addr == 5'h0C);
  assign wr_set = bus_wr && (bus_addr == 5'h10);
  assign wr_clr = bus_wr && (bus_addr == 5'h14);

  // R9: output only after pending with both master bits on
  assert_irq_qualified_R9: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past((pend_w != '0) && (master_w == 2'b11)));

  // R3 / R2: every capture request lands in status
  assert_capture_lands_R3: assert property (@(posedge clk) disable iff (rst)
    ((status_w & $past(set_w)) == $past(set_w)));

  // R4: acknowledged bits clear unless a new request arrived
  assert_ack_clears_R4: assert property (@(posedge clk) disable iff (rst)
    wr_ack |=> ((status_w & $past(bus_wdata[NUM_LINES-1:0]) & ~$past(set_w)) == '0));

  // R6: set-enable makes written ones enabled
  assert_set_enable_R6: assert property (@(posedge clk) disable iff (rst)
    wr_set |=> (($past(bus_wdata[NUM_LINES-1:0]) & ~enable_w) == '0));

  // R7: clear-enable removes written ones
  assert_clear_enable_R7: assert property (@(posedge clk) disable iff (rst)
    wr_clr |=> ((enable_w & $past(bus_wdata[NUM_LINES-1:0])) == '0));

  // R10: vector names the lowest pending line
  assert_vector_lowest_R10: assert property (@(posedge clk) disable iff (rst)
    vec_valid_w |-> (pend_w[vec_idx_w] &&
      ((pend_w & ((NUM_LINES'(1) << vec_idx_w) - NUM_LINES'(1))) == '0)));

  // R10: no vector without a pending line
  assert_vector_empty_R10: assert property (@(posedge clk) disable iff (rst)
    !vec_valid_w |-> (pend_w == '0));
endmodule

bind vec_irq_ctrl vic_checker #(
  .NUM_LINES(NUM_LINES),
  .DATA_W   (DATA_W),
  .IDX_W    (IDX_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_addr   (bus_addr),
  .bus_wr     (bus_wr),
  .bus_wdata  (bus_wdata),
  .irq_o      (irq_o),
  .set_w      (set_w),
  .status_w   (status_w),
  .enable_w   (enable_w),
  .pend_w     (pend_w),
  .master_w   (master_w),
  .vec_valid_w(vec_valid_w),
  .vec_idx_w  (vec_idx_w)
);

// File: tb/vec_irq_ctrl_test.sv
`timescale 1ns/1ps
module vec_irq_ctrl_test;
  localparam int NL = 32;
  // op: 0 write, 1 read-compare, 2 drive lines and settle, 3 check irq_o
  localparam int NV = 51;
  localparam logic [42:0] VECS [0:NV-1] = '{
    {2'd0, 5'h1C, 32'h0000_0003, 4'd12},
    {2'd1, 5'h1C, 32'h0000_0003, 4'd12}, // R12
    {2'd0, 5'h08, 32'h0000_0110, 4'd5},
    {2'd1, 5'h08, 32'h0000_0110, 4'd5},  // R5
    {2'd0, 5'h10, 32'h0000_0003, 4'd6},
    {2'd1, 5'h08, 32'h0000_0113, 4'd6},  // R6
    {2'd0, 5'h14, 32'h0000_0101, 4'd7},
    {2'd1, 5'h08, 32'h0000_0012, 4'd7},  // R7
    {2'd2, 5'h00, 32'h0000_0010, 4'd2},
    {2'd1, 5'h00, 32'h0000_0010, 4'd2},  // R2
    {2'd1, 5'h04, 32'h0000_0010, 4'd8},  // R8
    {2'd1, 5'h18, 32'h0000_0004, 4'd10}, // R10
    {2'd3, 5'h00, 32'h0000_0001, 4'd9},  // R9
    {2'd2, 5'h00, 32'h0000_0000, 4'd2},
    {2'd1, 5'h00, 32'h0000_0010, 4'd2},  // R2 held after fall
    {2'd0, 5'h0C, 32'h0000_0010, 4'd4},
    {2'd1, 5'h00, 32'h0000_0000, 4'd4},  // R4
    {2'd3, 5'h00, 32'h0000_0000, 4'd9},  // R9
    {2'd1, 5'h18, 32'hFFFF_FFFF, 4'd10}, // R10
    {2'd2, 5'h00, 32'h0000_0100, 4'd3},
    {2'd1, 5'h00, 32'h0000_0100, 4'd3},  // R3
    {2'd1, 5'h04, 32'h0000_0000, 4'd8},  // R8
    {2'd3, 5'h00, 32'h0000_0000, 4'd9},  // R9
    {2'd0, 5'h0C, 32'h0000_0100, 4'd3},
    {2'd1, 5'h00, 32'h0000_0100, 4'd3},  // R3 ack ineffective
    {2'd0, 5'h10, 32'h0000_0100, 4'd6},
    {2'd1, 5'h04, 32'h0000_0100, 4'd8},  // R8
    {2'd1, 5'h18, 32'h0000_0008, 4'd10}, // R10
    {2'd3, 5'h00, 32'h0000_0001, 4'd9},  // R9
    {2'd2, 5'h00, 32'h0000_0102, 4'd2},
    {2'd1, 5'h00, 32'h0000_0102, 4'd2},  // R2
    {2'd1, 5'h18, 32'h0000_0001, 4'd10}, // R10 lowest wins
    {2'd0, 5'h00, 32'h0000_0000, 4'd11},
    {2'd1, 5'h00, 32'h0000_0102, 4'd11}, // R11
    {2'd0, 5'h18, 32'h0000_0005, 4'd11},
    {2'd1, 5'h18, 32'h0000_0001, 4'd11}, // R11
    {2'd1, 5'h0C, 32'h0000_0000, 4'd11}, // R11
    {2'd0, 5'h1C, 32'h0000_0001, 4'd9},
    {2'd3, 5'h00, 32'h0000_0000, 4'd9},  // R9 one master bit
    {2'd1, 5'h04, 32'h0000_0102, 4'd8},  // R8
    {2'd0, 5'h1C, 32'h0000_0003, 4'd9},
    {2'd3, 5'h00, 32'h0000_0001, 4'd9},  // R9
    {2'd2, 5'h00, 32'h0000_0000, 4'd4},
    {2'd0, 5'h0C, 32'hFFFF_FFFF, 4'd4},
    {2'd1, 5'h00, 32'h0000_0000, 4'd4},  // R4 clear all
    {2'd3, 5'h00, 32'h0000_0000, 4'd9},  // R9
    {2'd1, 5'h18, 32'hFFFF_FFFF, 4'd10}, // R10
    {2'd0, 5'h08, 32'h0000_0000, 4'd5},
    {2'd1, 5'h08, 32'h0000_0000, 4'd5},  // R5
    {2'd0, 5'h1C, 32'hFFFF_FFFF, 4'd12},
    {2'd1, 5'h1C, 32'h0000_0003, 4'd12}  // R12
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [4:0]    bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic          bus_rd = 1'b0;
  logic [31:0]   bus_rdata;
  logic [NL-1:0] irq_lines = '0;
  logic          irq_o;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  vec_irq_ctrl #(
    .NUM_LINES  (NL),
    .DATA_W     (32),
    .SYNC_STAGES(2),
    .EDGE_MASK  (32'h0000_00FF)
  ) uut (
    .clk      (clk),
    .rst      (rst),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_wdata(bus_wdata),
    .bus_rd   (bus_rd),
    .bus_rdata(bus_rdata),
    .irq_lines(irq_lines),
    .irq_o    (irq_o)
  );

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [4:0] a, input logic [31:0] exp, input int req);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk); #1;
    check(req, bus_rdata, exp);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    #1 check(1, {31'b0, irq_o}, 32'h0);
    rd_chk(5'h00, 32'h0, 1);
    rd_chk(5'h08, 32'h0, 1);
    rd_chk(5'h1C, 32'h0, 1);
    rd_chk(5'h18, 32'hFFFF_FFFF, 1);

    for (int i = 0; i < NV; i++) begin
      logic [1:0]  op;
      logic [4:0]  a;
      logic [31:0] d;
      int          rq;
      op = VECS[i][42:41];
      a  = VECS[i][40:36];
      d  = VECS[i][35:4];
      rq = int'(VECS[i][3:0]);
      case (op)
        2'd0: wr(a, d);
        2'd1: rd_chk(a, d, rq);
        2'd2: begin @(negedge clk); irq_lines = d[NL-1:0]; settle(6); end
        default: begin settle(2); check(rq, {31'b0, irq_o}, d); end
      endcase
    end

    // R2 edge line held high does not re-latch after acknowledge
    wr(5'h08, 32'h0000_0004);
    wr(5'h1C, 32'h3);
    @(negedge clk); irq_lines = 32'h0000_0004; settle(6);
    rd_chk(5'h00, 32'h0000_0004, 2);
    wr(5'h0C, 32'h0000_0004);
    settle(4);
    rd_chk(5'h00, 32'h0, 2);
    settle(2);
    check(2, {31'b0, irq_o}, 32'h0);

    // R2 second rising edge latches again
    @(negedge clk); irq_lines = '0; settle(4);
    @(negedge clk); irq_lines = 32'h0000_0004; settle(6);
    rd_chk(5'h00, 32'h0000_0004, 2);
    check(2, {31'b0, irq_o}, 32'h1);

    // R1 reset mid-run clears everything
    @(negedge clk); irq_lines = '0; settle(4);
    @(negedge clk); rst = 1'b1;
    settle(2);
    @(negedge clk); rst = 1'b0;
    #1 check(1, {31'b0, irq_o}, 32'h0);
    rd_chk(5'h00, 32'h0, 1);
    rd_chk(5'h08, 32'h0, 1);
    rd_chk(5'h1C, 32'h0, 1);
    rd_chk(5'h18, 32'hFFFF_FFFF, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule